// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a processor whose datapath shares one memory and one ALU across several clock cycles per instruction. It is a Moore state machine with ten states. Every datapath control signal it drives depends only on the current state. The only input that steers it is the 6-bit opcode held in the instruction register. The opcode is consulted in two states: the decode state and the address state. In the decode state it selects the instruction class. In the address state it separates a load from a store.

Every instruction starts with a fetch state and a decode state. After that, the path splits by class. A load takes five cycles, a store four, a register-to-register operation four, and a conditional branch or a jump three. After the last state of any path, the machine returns to fetch. A synchronous active-high reset places the machine in fetch.

State numbering used in the requirements:

| Number | State |
|---|---|
| 0 | fetch |
| 1 | decode |
| 2 | address |
| 3 | memory read |
| 4 | load write-back |
| 5 | memory write |
| 6 | execute |
| 7 | register write-back |
| 8 | branch |
| 9 | jump |

Opcode encodings: 0 is register-register, 35 is load, 43 is store, 4 is branch-if-equal, and 2 is jump.

Top module: `mcc_control`

## Requirements
- R1: Reset is synchronous. A clock edge with `rst` high puts the machine in fetch (state 0), whatever its current state or opcode.
- R2: Fetch drives `mem_rd`, `ir_ld` and `pc_wr` high, with `alu_b_sel`=01 and every other select at 0. The next state is always decode (state 1).
- R3: Decode drives `alu_b_sel`=11 with `alu_a_sel`=0 and `alu_mode`=00. Its next state is: address (2) for opcode 35 or 43, execute (6) for 0, branch (8) for 4, jump (9) for 2, and fetch (0) for any other opcode.
- R4: The load path is 0,1,2,3,4, then back to 0. In the address state, `alu_a_sel`=1 and `alu_b_sel`=10. In the memory-read state, `mem_rd`=1 and `addr_sel`=1. In the load write-back state, `rf_wr`=1, `wb_sel`=1 and `rf_dst`=0.
- R5: The store path is 0,1,2,5, then back to 0. In the memory-write state, `mem_wr`=1 and `addr_sel`=1.
- R6: The register-register path is 0,1,6,7, then back to 0. In the execute state, `alu_a_sel`=1, `alu_b_sel`=00 and `alu_mode`=10. In the register write-back state, `rf_wr`=1, `rf_dst`=1 and `wb_sel`=0.
- R7: The branch path is 0,1,8: the branch state drives `pc_wr_cond`=1, `pc_src`=01, `alu_mode`=01 and `alu_a_sel`=1. The jump path is 0,1,9: the jump state drives `pc_wr`=1 and `pc_src`=10. Both paths return to 0.
- R8: A write enable (`pc_wr`, `pc_wr_cond`, `mem_rd`, `mem_wr`, `ir_ld`, `rf_wr`) is high only in the states listed above, and every select not listed for a state is 0. At most one of `mem_rd`, `mem_wr` and `rf_wr` is high in any cycle.
- R9: The opcode is ignored in every state except decode and address. Changing it during fetch, execute or write-back does not change the path.
- R10: From the address state, opcode 43 leads to memory write (5) and any other opcode leads to memory read (3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| pc_wr | output | 1 | Unconditional program counter write |
| pc_wr_cond | output | 1 | Program counter write if the ALU reports equality |
| addr_sel | output | 1 | Memory address source: 0 program counter, 1 ALU result register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_ld | output | 1 | Instruction register load |
| wb_sel | output | 1 | Register write data: 0 ALU result, 1 memory data register |
| pc_src | output | 2 | Program counter source: 00 ALU, 01 ALU result register, 10 jump target |
| alu_mode | output | 2 | ALU operation: 00 add, 01 compare, 10 from function field |
| alu_a_sel | output | 1 | ALU A operand: 0 program counter, 1 register A |
| alu_b_sel | output | 2 | ALU B operand: 00 register B, 01 constant 4, 10 immediate, 11 shifted immediate |
| rf_wr | output | 1 | Register file write enable |
| rf_dst | output | 1 | Destination register field: 0 bits 20..16, 1 bits 15..11 |

## Verification
The outputs are a combinational function of the state register, so each output vector is valid in the same cycle as its state. A new state appears one rising edge after the opcode seen in decode or address selects it. The bench drives the opcode and samples all sixteen control bits at falling edges. It compares the sampled bits with the expected vector of state k of the path at the k-th falling edge after the instruction starts, and it checks fetch again one edge after the last state. A reset raised at a falling edge is checked at the next falling edge, and opcode changes are placed at falling edges so that the next rising edge is the first to see them.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    localparam int OPC_W   = 6;
    localparam int STATE_W = 4;

    localparam logic [OPC_W-1:0] OPC_RR    = 6'd0;
    localparam logic [OPC_W-1:0] OPC_JMP   = 6'd2;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'd4;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'd35;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'd43;

    typedef enum logic [STATE_W-1:0] {
        S_FETCH  = 4'd0,
        S_DECODE = 4'd1,
        S_ADDR   = 4'd2,
        S_MEMRD  = 4'd3,
        S_LDWB   = 4'd4,
        S_MEMWR  = 4'd5,
        S_EXEC   = 4'd6,
        S_RRWB   = 4'd7,
        S_BRANCH = 4'd8,
        S_JUMP   = 4'd9
    } mcc_state_e;

    typedef enum logic [2:0] {
        C_RR, C_MEM, C_BEQ, C_JMP, C_BAD
    } mcc_class_e;

    typedef struct packed {
        logic       pc_wr;
        logic       pc_wr_cond;
        logic       addr_sel;
        logic       mem_rd;
        logic       mem_wr;
        logic       ir_ld;
        logic       wb_sel;
        logic [1:0] pc_src;
        logic [1:0] alu_mode;
        logic       alu_a_sel;
        logic [1:0] alu_b_sel;
        logic       rf_wr;
        logic       rf_dst;
    } mcc_ctrl_t;

    function automatic mcc_class_e classify(input logic [OPC_W-1:0] op);
        case (op)
            OPC_RR:               return C_RR;
            OPC_LOAD, OPC_STORE:  return C_MEM;
            OPC_BEQ:              return C_BEQ;
            OPC_JMP:              return C_JMP;
            default:              return C_BAD;
        endcase
    endfunction

endpackage

// File: rtl/mcc_next_state.sv
module mcc_next_state
    import mcc_pkg::*;
(
    input  mcc_state_e       cur,
    input  logic [OPC_W-1:0] opcode,
    output mcc_state_e       nxt
);
    mcc_class_e cls;

    always_comb begin
        cls = classify(opcode);
        nxt = S_FETCH;
        case (cur)
            S_FETCH:  nxt = S_DECODE;
            S_DECODE: begin
                case (cls)
                    C_MEM:   nxt = S_ADDR;
                    C_RR:    nxt = S_EXEC;
                    C_BEQ:   nxt = S_BRANCH;
                    C_JMP:   nxt = S_JUMP;
                    default: nxt = S_FETCH;
                endcase
            end
            S_ADDR:   nxt = (opcode == OPC_STORE) ? S_MEMWR : S_MEMRD;
            S_MEMRD:  nxt = S_LDWB;
            S_EXEC:   nxt = S_RRWB;
            default:  nxt = S_FETCH;
        endcase
    end
endmodule

// File: rtl/mcc_output_decode.sv
module mcc_output_decode
    import mcc_pkg::*;
(
    input  mcc_state_e cur,
    output mcc_ctrl_t  ctl
);
    always_comb begin
        ctl = '0;
        case (cur)
            S_FETCH: begin
                ctl.mem_rd    = 1'b1;
                ctl.ir_ld     = 1'b1;
                ctl.pc_wr     = 1'b1;
                ctl.alu_b_sel = 2'b01;
            end
            S_DECODE: ctl.alu_b_sel = 2'b11;
            S_ADDR: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = 2'b10;
            end
            S_MEMRD: begin
                ctl.mem_rd   = 1'b1;
                ctl.addr_sel = 1'b1;
            end
            S_LDWB: begin
                ctl.rf_wr  = 1'b1;
                ctl.wb_sel = 1'b1;
            end
            S_MEMWR: begin
                ctl.mem_wr   = 1'b1;
                ctl.addr_sel = 1'b1;
            end
            S_EXEC: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_mode  = 2'b10;
            end
            S_RRWB: begin
                ctl.rf_wr  = 1'b1;
                ctl.rf_dst = 1'b1;
            end
            S_BRANCH: begin
                ctl.alu_a_sel  = 1'b1;
                ctl.alu_mode   = 2'b01;
                ctl.pc_wr_cond = 1'b1;
                ctl.pc_src     = 2'b01;
            end
            S_JUMP: begin
                ctl.pc_wr  = 1'b1;
                ctl.pc_src = 2'b10;
            end
            default: ctl = '0;
        endcase
    end

    always_comb begin
        assert_rdwr_excl_R8: assert (!(ctl.mem_rd && ctl.mem_wr));
    end
endmodule

// File: rtl/mcc_control.sv
module mcc_control
    import mcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    output logic             pc_wr,
    output logic             pc_wr_cond,
    output logic             addr_sel,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             ir_ld,
    output logic             wb_sel,
    output logic [1:0]       pc_src,
    output logic [1:0]       alu_mode,
    output logic             alu_a_sel,
    output logic [1:0]       alu_b_sel,
    output logic             rf_wr,
    output logic             rf_dst
);
    mcc_state_e state_q;
    mcc_state_e state_d;
    mcc_ctrl_t  ctl;

    mcc_next_state u_next (
        .cur    (state_q),
        .opcode (opcode),
        .nxt    (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_FETCH;
        else     state_q <= state_d;
    end

    mcc_output_decode u_out (
        .cur (state_q),
        .ctl (ctl)
    );

    assign pc_wr      = ctl.pc_wr;
    assign pc_wr_cond = ctl.pc_wr_cond;
    assign addr_sel   = ctl.addr_sel;
    assign mem_rd     = ctl.mem_rd;
    assign mem_wr     = ctl.mem_wr;
    assign ir_ld      = ctl.ir_ld;
    assign wb_sel     = ctl.wb_sel;
    assign pc_src     = ctl.pc_src;
    assign alu_mode   = ctl.alu_mode;
    assign alu_a_sel  = ctl.alu_a_sel;
    assign alu_b_sel  = ctl.alu_b_sel;
    assign rf_wr      = ctl.rf_wr;
    assign rf_dst     = ctl.rf_dst;

    assert_reset_fetch_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ir_ld && mem_rd && !addr_sel));
    assert_fetch_decode_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_FETCH) |=> (state_q == S_DECODE));
    assert_load_chain_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_MEMRD) |=> (rf_wr && wb_sel));
    assert_exec_wb_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_EXEC) |=> (rf_wr && rf_dst));
    assert_path_end_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q inside {S_LDWB, S_MEMWR, S_RRWB, S_BRANCH, S_JUMP}) |=> ir_ld);
    assert_one_access_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd, mem_wr, rf_wr}));
    assert_store_route_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_ADDR && opcode == OPC_STORE) |=> (mem_wr && !mem_rd));
endmodule

// File: tb/mcc_control_tb.sv
module mcc_control_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'd0;
    logic pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_ld, wb_sel;
    logic [1:0] pc_src, alu_mode, alu_b_sel;
    logic alu_a_sel, rf_wr, rf_dst;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcc_control u_dut (
        .clk(clk), .rst(rst), .opcode(opcode),
        .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .addr_sel(addr_sel),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_ld(ir_ld), .wb_sel(wb_sel),
        .pc_src(pc_src), .alu_mode(alu_mode), .alu_a_sel(alu_a_sel),
        .alu_b_sel(alu_b_sel), .rf_wr(rf_wr), .rf_dst(rf_dst)
    );

    // vector: {opcode[28:23], len[22:20], state nibbles k at [4k+3:4k]}
    localparam logic [28:0] VEC [NVEC] = '{
        {6'd35, 3'd5, 20'h43210},   // R4 load
        {6'd43, 3'd4, 20'h05210},   // R5 store
        {6'd0,  3'd4, 20'h07610},   // R6 register-register
        {6'd4,  3'd3, 20'h00810},   // R7 branch
        {6'd2,  3'd3, 20'h00910},   // R7 jump
        {6'd63, 3'd2, 20'h00010},   // R3 unknown opcode
        {6'd17, 3'd2, 20'h00010},   // R3 unknown opcode
        {6'd35, 3'd5, 20'h43210}    // R4 load again
    };

    function automatic logic [15:0] expect_ctl(input int s);
        logic pw = 0, pc = 0, as = 0, rd = 0, wr = 0, ir = 0, wb = 0;
        logic [1:0] src = 0, mode = 0, bsel = 0;
        logic asel = 0, rw = 0, dst = 0;
        case (s)
            0: begin rd = 1; ir = 1; pw = 1; bsel = 2'b01; end
            1: bsel = 2'b11;
            2: begin asel = 1; bsel = 2'b10; end
            3: begin rd = 1; as = 1; end
            4: begin rw = 1; wb = 1; end
            5: begin wr = 1; as = 1; end
            6: begin asel = 1; mode = 2'b10; end
            7: begin rw = 1; dst = 1; end
            8: begin asel = 1; mode = 2'b01; pc = 1; src = 2'b01; end
            9: begin pw = 1; src = 2'b10; end
            default: ;
        endcase
        return {pw, pc, as, rd, wr, ir, wb, src, mode, asel, bsel, rw, dst};
    endfunction

    function automatic logic [15:0] actual_ctl();
        return {pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_ld, wb_sel,
                pc_src, alu_mode, alu_a_sel, alu_b_sel, rf_wr, rf_dst};
    endfunction

    task automatic check_state(input int s, input string req);
        checks++;
        if (actual_ctl() !== expect_ctl(s)) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (state %0d)",
                     req, actual_ctl(), expect_ctl(s), s);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_state(0, "R1 reset to fetch");

        // table walk: R2 fetch->decode, R3..R7 paths, R8 all fields
        for (int v = 0; v < NVEC; v++) begin
            opcode = VEC[v][28:23];
            for (int k = 0; k < int'(VEC[v][22:20]); k++) begin
                check_state(int'(VEC[v][4*k +: 4]), k == 0 ? "R2 fetch" : "R3-path R8 vector");
                @(negedge clk);
            end
        end
        check_state(0, "R4 return to fetch");

        // R1: reset in the middle of a load
        opcode = 6'd35;
        @(negedge clk); @(negedge clk);
        check_state(2, "R4 address state");
        rst = 1'b1;
        @(negedge clk);
        check_state(0, "R1 mid-instruction reset");
        rst = 1'b0;
        @(negedge clk);
        check_state(1, "R1 resume decode");
        opcode = 6'd2;
        @(negedge clk);
        check_state(9, "R7 jump after reset");
        @(negedge clk);

        // R9: opcode changes outside decode/address are ignored
        opcode = 6'd2;                      // during fetch
        check_state(0, "R9 fetch");
        @(negedge clk);
        opcode = 6'd0;                      // decode sees R-type
        check_state(1, "R9 decode");
        @(negedge clk);
        opcode = 6'd2;                      // execute sees jump
        check_state(6, "R9 execute");
        @(negedge clk);
        opcode = 6'd4;
        check_state(7, "R9 write-back unaffected");
        @(negedge clk);
        check_state(0, "R9 back to fetch");

        // R10: address state routing on the opcode present there
        opcode = 6'd35;
        @(negedge clk); @(negedge clk);
        opcode = 6'd0;                      // not store -> memory read
        check_state(2, "R10 address");
        @(negedge clk);
        check_state(3, "R10 non-store goes to read");
        @(negedge clk);
        check_state(4, "R10 load write-back");
        @(negedge clk);
        opcode = 6'd35;
        @(negedge clk); @(negedge clk);
        opcode = 6'd43;                     // store at address state
        @(negedge clk);
        check_state(5, "R10 store goes to write");
        @(negedge clk);
        check_state(0, "R5 store returns");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule